// File: doc/BRIEF.md
# Flash Block Erase Sequencer

This block runs the erase-and-check procedure for an on-chip flash array, one block at a time. A start pulse carries a bitmask of the blocks to erase. The sequencer first raises the array's global program-enable. It then handles each requested block in ascending index order, with exactly one block-select bit high at a time.

For each attempt the sequencer arms the watchdog and opens an erase window with a setup strobe. It fires a timed erase pulse, closes the window and disarms the watchdog. It then scans the whole block: for each 32-bit word it issues a dummy write of 0xFF, waits, and reads the word back. Any word that is not all ones ends the scan. The block then gets another pulse, up to an attempt limit. A block that still fails at the limit aborts the run with a failure flag. When every requested block passes, the run ends with a done flag.

Every wait is a whole number of microseconds, turned into clock cycles by one cycles-per-microsecond parameter. A single shared counter times all of them. Block count, block size in words and all wait lengths are parameters. Block b starts at byte address b × 4 × words-per-block, and words are 4 bytes apart.

Top module: `flash_erase_seq`

## Requirements
- R1: While reset is held and right after it, every strobe output, the block select, done and fail are all low.
- R2: A start with a non-zero mask raises program-enable at once. The first block select follows exactly T_EN_US microseconds later, and program-enable stays high until the run ends.
- R3: Requested blocks are handled one after another in ascending index order. At most one block-select bit is ever high, and it stays high through all attempts on that block.
- R4: Each attempt raises setup and watchdog-enable together. Erase rises T_SETUP_US later and stays high for T_PULSE_US. Setup drops T_PHOLD_US after erase falls.
- R5: The watchdog stays enabled for T_SHOLD_US after setup drops. It is disabled on the same edge that raises verify, so it covers the whole erase window and never overlaps verify.
- R6: The first dummy write of a scan comes T_VSET_US after verify rises and targets the selected block's start address.
- R7: For every scanned word, a one-cycle dummy write of data 0xFF goes to the word's address. The one-cycle read of the same address follows 2 × CYC_PER_US + 1 cycles after the write. The word passes only if all 32 read bits are 1. After a pass the address steps by 4, until the block's last word has passed.
- R8: A failed word drops verify. Setup and watchdog rise again T_VOFF_US later for a new attempt. The attempt count starts at 1 for every block, so each block may take up to MAX_TRY pulses.
- R9: If the block's MAX_TRY-th attempt fails, verify drops and T_VOFF_US later program-enable and select drop and fail rises. Blocks after it are never selected.
- R10: When the last requested block passes, verify drops, and T_VOFF_US later program-enable drops and done rises.
- R11: A start pulse while a run is in progress is ignored. It does not change which blocks are erased.
- R12: Done and fail keep their values until the next start. That start clears them on the following edge.
- R13: A start with an all-zero mask raises done on the next edge and fail stays low. No strobe toggles and program-enable stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle start request |
| blk_mask_i | input | NUM_BLK | Blocks to erase, sampled with start_i |
| prog_en_o | output | 1 | Global program/erase enable to the array |
| blk_sel_o | output | NUM_BLK | One-hot block select |
| wdog_en_o | output | 1 | Watchdog run enable |
| setup_o | output | 1 | Erase setup strobe |
| pulse_o | output | 1 | Erase pulse strobe |
| verify_o | output | 1 | Erase-verify mode strobe |
| dwr_o | output | 1 | Dummy write strobe |
| rd_o | output | 1 | Verify read strobe; rdata_i is sampled in this cycle |
| addr_o | output | ADDR_W | Byte address of the verify write and read |
| dwr_data_o | output | 8 | Dummy write data (always 0xFF) |
| rdata_i | input | 32 | Read data from the array |
| done_o | output | 1 | All requested blocks erased |
| fail_o | output | 1 | A block did not erase within MAX_TRY attempts |

## Verification
The flash model in the bench makes each block read clean only after a set number of pulses. It plants its stuck word at the first, a middle or the last word of the block, so a scan that stops one word early would report a pass too soon. Two blocks that each need 40 pulses catch an attempt counter that is not reset per block, because the second block would then fail. A block that needs exactly 61 pulses, and another that never clears, test the limit on both sides: an off-by-one would fail the first or grant the second an extra pulse. Edge-to-edge gap measurements catch a swapped or missing wait. A second start sent mid-run checks that the request is ignored, since accepting it would erase extra blocks.

// File: rtl/flash_erase_pkg.sv
`timescale 1ns/1ps
package flash_erase_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ENABLE,
      ST_SETUP,
      ST_PULSE,
      ST_PHOLD,
      ST_SHOLD,
      ST_VSET,
      ST_DWR,
      ST_GAP,
      ST_READ,
      ST_VPASS,
      ST_VFAIL
   } fe_state_e;

   function automatic int fe_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int fe_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/fe_timer.sv
`timescale 1ns/1ps
module fe_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic [CNT_W-1:0] lim_i,
   output logic             hit_o
);

   logic [CNT_W-1:0] cnt_q;

   assign hit_o = (cnt_q == lim_i - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (!hit_o) cnt_q <= cnt_q + CNT_W'(1);
   end

   // R4: the shared counter never runs past the wait of the current state
   a_r4_cnt_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < lim_i);

endmodule

// File: rtl/fe_pick.sv
`timescale 1ns/1ps
module fe_pick #(
   parameter int N     = 4,
   parameter int IDX_W = 2
) (
   input  logic [N-1:0]     req_i,
   output logic [N-1:0]     gnt_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             any_o
);

   logic [N:0] seen;
   assign seen[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_lane
      assign gnt_o[i]  = req_i[i] & ~seen[i];
      assign seen[i+1] = seen[i] | req_i[i];
   end

   assign any_o = seen[N];

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < N; i++) begin
         if (gnt_o[i]) idx_o = IDX_W'(i);
      end
   end

endmodule

// File: rtl/fe_addr.sv
`timescale 1ns/1ps
module fe_addr #(
   parameter int ADDR_W = 16,
   parameter int WORDS  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic              step_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              last_o
);

   localparam int WC_W = (WORDS > 1) ? $clog2(WORDS) : 1;

   logic [WC_W-1:0] wcnt_q;

   assign last_o = (wcnt_q == WC_W'(WORDS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_o <= '0;
         wcnt_q <= '0;
      end else if (load_i) begin
         addr_o <= base_i;
         wcnt_q <= '0;
      end else if (step_i) begin
         addr_o <= addr_o + ADDR_W'(4);
         wcnt_q <= wcnt_q + WC_W'(1);
      end
   end

   // R7: a step moves the verify address forward by exactly one longword
   a_r7_step_one_word: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i) |=> (addr_o == $past(addr_o) + ADDR_W'(4)));

endmodule

// File: rtl/flash_erase_seq.sv
`timescale 1ns/1ps
module flash_erase_seq
   import flash_erase_pkg::*;
#(
   parameter int NUM_BLK     = 4,
   parameter int BLK_WORDS   = 64,
   parameter int ADDR_W      = 16,
   parameter int CYC_PER_US  = 50,
   parameter int T_EN_US     = 10,
   parameter int T_SETUP_US  = 200,
   parameter int T_PULSE_US  = 5000,
   parameter int T_PHOLD_US  = 10,
   parameter int T_SHOLD_US  = 10,
   parameter int T_VSET_US   = 20,
   parameter int T_GAP_US    = 2,
   parameter int T_VOFF_US   = 5,
   parameter int MAX_TRY     = 61
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [NUM_BLK-1:0] blk_mask_i,
   output logic               prog_en_o,
   output logic [NUM_BLK-1:0] blk_sel_o,
   output logic               wdog_en_o,
   output logic               setup_o,
   output logic               pulse_o,
   output logic               verify_o,
   output logic               dwr_o,
   output logic               rd_o,
   output logic [ADDR_W-1:0]  addr_o,
   output logic [7:0]         dwr_data_o,
   input  logic [31:0]        rdata_i,
   output logic               done_o,
   output logic               fail_o
);

   localparam int IDX_W   = fe_bits(NUM_BLK);
   localparam int TRY_W   = $clog2(MAX_TRY + 1);
   localparam int LIM_MAX = fe_max(fe_max(fe_max(T_EN_US, T_SETUP_US), fe_max(T_PULSE_US, T_PHOLD_US)),
                                   fe_max(fe_max(T_SHOLD_US, T_VSET_US), fe_max(T_GAP_US, T_VOFF_US)))
                            * CYC_PER_US;
   localparam int CNT_W   = $clog2(LIM_MAX + 1);

   localparam logic [CNT_W-1:0]  L_EN    = CNT_W'(T_EN_US * CYC_PER_US);
   localparam logic [CNT_W-1:0]  L_SETUP = CNT_W'(T_SETUP_US * CYC_PER_US);
   localparam logic [CNT_W-1:0]  L_PULSE = CNT_W'(T_PULSE_US * CYC_PER_US);
   localparam logic [CNT_W-1:0]  L_PHOLD = CNT_W'(T_PHOLD_US * CYC_PER_US);
   localparam logic [CNT_W-1:0]  L_SHOLD = CNT_W'(T_SHOLD_US * CYC_PER_US);
   localparam logic [CNT_W-1:0]  L_VSET  = CNT_W'(T_VSET_US * CYC_PER_US);
   localparam logic [CNT_W-1:0]  L_GAP   = CNT_W'(T_GAP_US * CYC_PER_US);
   localparam logic [CNT_W-1:0]  L_VOFF  = CNT_W'(T_VOFF_US * CYC_PER_US);
   localparam logic [ADDR_W-1:0] BLK_BYTES = ADDR_W'(BLK_WORDS * 4);
   localparam logic [TRY_W-1:0]  TRY_LAST  = TRY_W'(MAX_TRY);

   // elaboration-time parameter checks
   if (NUM_BLK < 1) begin : g_chk_nblk
      $error("flash_erase_seq: NUM_BLK must be at least 1");
   end
   if (BLK_WORDS < 1) begin : g_chk_words
      $error("flash_erase_seq: BLK_WORDS must be at least 1");
   end
   if (NUM_BLK * BLK_WORDS * 4 > (1 << ADDR_W)) begin : g_chk_addr
      $error("flash_erase_seq: ADDR_W too narrow for all blocks");
   end
   if (CYC_PER_US < 1 || MAX_TRY < 1) begin : g_chk_rate
      $error("flash_erase_seq: CYC_PER_US and MAX_TRY must be positive");
   end
   if (T_EN_US < 1 || T_SETUP_US < 1 || T_PULSE_US < 1 || T_PHOLD_US < 1 ||
       T_SHOLD_US < 1 || T_VSET_US < 1 || T_GAP_US < 1 || T_VOFF_US < 1) begin : g_chk_wait
      $error("flash_erase_seq: every wait must be at least 1 us");
   end

   fe_state_e          state_q, state_d;
   logic [NUM_BLK-1:0] pend_q, sel_q;
   logic [IDX_W-1:0]   idx_q;
   logic [TRY_W-1:0]   tries_q;
   logic               done_q, fail_q;

   logic [CNT_W-1:0]   lim;
   logic               hit;
   logic [NUM_BLK-1:0] gnt;
   logic [IDX_W-1:0]   gidx;
   logic               gany;
   logic               word_ok, last_word;
   logic               addr_load, addr_step;
   logic [ADDR_W-1:0]  base;

   // wait length of the current state
   always_comb begin
      unique case (state_q)
         ST_ENABLE: lim = L_EN;
         ST_SETUP:  lim = L_SETUP;
         ST_PULSE:  lim = L_PULSE;
         ST_PHOLD:  lim = L_PHOLD;
         ST_SHOLD:  lim = L_SHOLD;
         ST_VSET:   lim = L_VSET;
         ST_GAP:    lim = L_GAP;
         ST_VPASS,
         ST_VFAIL:  lim = L_VOFF;
         default:   lim = CNT_W'(1);
      endcase
   end

   fe_timer #(.CNT_W(CNT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (state_d != state_q),
      .lim_i (lim),
      .hit_o (hit)
   );

   fe_pick #(.N(NUM_BLK), .IDX_W(IDX_W)) u_pick (
      .req_i (pend_q & ~sel_q),
      .gnt_o (gnt),
      .idx_o (gidx),
      .any_o (gany)
   );

   assign base      = ADDR_W'(idx_q) * BLK_BYTES;
   assign addr_load = (state_q == ST_VSET) && hit;
   assign word_ok   = &rdata_i;
   assign addr_step = (state_q == ST_READ) && word_ok && !last_word;

   fe_addr #(.ADDR_W(ADDR_W), .WORDS(BLK_WORDS)) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (addr_load),
      .base_i (base),
      .step_i (addr_step),
      .addr_o (addr_o),
      .last_o (last_word)
   );

   // next state
   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (start_i && (|blk_mask_i)) state_d = ST_ENABLE;
         ST_ENABLE: if (hit) state_d = ST_SETUP;
         ST_SETUP:  if (hit) state_d = ST_PULSE;
         ST_PULSE:  if (hit) state_d = ST_PHOLD;
         ST_PHOLD:  if (hit) state_d = ST_SHOLD;
         ST_SHOLD:  if (hit) state_d = ST_VSET;
         ST_VSET:   if (hit) state_d = ST_DWR;
         ST_DWR:    state_d = ST_GAP;
         ST_GAP:    if (hit) state_d = ST_READ;
         ST_READ: begin
            if (!word_ok)      state_d = ST_VFAIL;
            else if (last_word) state_d = ST_VPASS;
            else               state_d = ST_DWR;
         end
         ST_VPASS:  if (hit) state_d = gany ? ST_SETUP : ST_IDLE;
         ST_VFAIL:  if (hit) state_d = (tries_q >= TRY_LAST) ? ST_IDLE : ST_SETUP;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pend_q  <= '0;
         sel_q   <= '0;
         idx_q   <= '0;
         tries_q <= '0;
         done_q  <= 1'b0;
         fail_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  pend_q <= blk_mask_i;
                  done_q <= ~(|blk_mask_i);
                  fail_q <= 1'b0;
               end
            end
            ST_ENABLE: begin
               if (hit) begin
                  sel_q   <= gnt;
                  idx_q   <= gidx;
                  tries_q <= TRY_W'(1);
               end
            end
            ST_VPASS: begin
               if (hit) begin
                  pend_q <= pend_q & ~sel_q;
                  sel_q  <= gnt;
                  if (gany) begin
                     idx_q   <= gidx;
                     tries_q <= TRY_W'(1);
                  end else begin
                     done_q <= 1'b1;
                  end
               end
            end
            ST_VFAIL: begin
               if (hit) begin
                  if (tries_q >= TRY_LAST) begin
                     sel_q  <= '0;
                     pend_q <= '0;
                     fail_q <= 1'b1;
                  end else begin
                     tries_q <= tries_q + TRY_W'(1);
                  end
               end
            end
            default: ;
         endcase
      end
   end

   // strobe decode
   assign prog_en_o  = (state_q != ST_IDLE);
   assign blk_sel_o  = sel_q;
   assign setup_o    = (state_q == ST_SETUP) || (state_q == ST_PULSE) || (state_q == ST_PHOLD);
   assign pulse_o    = (state_q == ST_PULSE);
   assign wdog_en_o  = setup_o || (state_q == ST_SHOLD);
   assign verify_o   = (state_q == ST_VSET) || (state_q == ST_DWR) ||
                       (state_q == ST_GAP)  || (state_q == ST_READ);
   assign dwr_o      = (state_q == ST_DWR);
   assign rd_o       = (state_q == ST_READ);
   assign dwr_data_o = 8'hFF;
   assign done_o     = done_q;
   assign fail_o     = fail_q;

   // R3: never more than one block selected
   a_r3_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(blk_sel_o));
   // R2: a block is only ever selected under program-enable
   a_r2_sel_under_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (|blk_sel_o) |-> prog_en_o);
   // R4: the erase pulse only fires inside the setup window with the watchdog armed
   a_r4_pulse_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |-> (setup_o && wdog_en_o && (|blk_sel_o)));
   // R4: erase rises only after setup was already high
   a_r4_setup_leads: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_o) |-> $past(setup_o));
   // R5: the watchdog is released exactly as verify starts
   a_r5_wdog_to_verify: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wdog_en_o) |-> (verify_o && !setup_o));
   // R8: attempt count stays within the limit
   a_r8_tries_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      tries_q <= TRY_LAST);
   // R9: a failed run leaves the array idle
   a_r9_fail_idle: assert property (@(posedge clk) disable iff (!rst_n)
      fail_o |-> (!prog_en_o && (blk_sel_o == '0) && !done_o));
   // R10: a finished run leaves the array idle
   a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!prog_en_o && !verify_o));
   // R11: a run only begins from a start request
   a_r11_begin_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog_en_o) |-> $past(start_i));

endmodule

// File: tb/sim_flash_erase_seq.sv
`timescale 1ns/1ps
module sim_flash_erase_seq;

   localparam int NB  = 4;
   localparam int BW  = 8;
   localparam int AW  = 12;
   localparam int CPU = 2;
   localparam int TSU = 50;
   localparam int TPU = 30;
   localparam int MT  = 61;

   // vector: [31:28] mask, [b*7 +: 7] pulses block b needs (>MT means never)
   localparam int NV = 6;
   localparam logic [31:0] VEC [NV] = '{
      32'h1000_0001,   // single block, one pulse
      32'hA040_0180,   // blocks 1 and 3, 3 and 2 pulses
      32'hF021_0081,   // all blocks, block 2 needs 4
      32'h6000_5F00,   // block 1 never clears -> fail, block 2 untouched
      32'h87A0_0000,   // block 3 needs exactly MT
      32'h3000_1428    // blocks 0 and 1 need 40 each
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          start;
   logic [NB-1:0] mask;
   logic          prog_en, wdog, setup, pulse, verify, dwr, rd, done, fail;
   logic [NB-1:0] sel;
   logic [AW-1:0] addr;
   logic [7:0]    dwr_data;
   logic [31:0]   rdata;

   flash_erase_seq #(
      .NUM_BLK(NB), .BLK_WORDS(BW), .ADDR_W(AW), .CYC_PER_US(CPU),
      .T_SETUP_US(TSU), .T_PULSE_US(TPU), .MAX_TRY(MT)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .blk_mask_i(mask),
      .prog_en_o(prog_en), .blk_sel_o(sel), .wdog_en_o(wdog), .setup_o(setup),
      .pulse_o(pulse), .verify_o(verify), .dwr_o(dwr), .rd_o(rd), .addr_o(addr),
      .dwr_data_o(dwr_data), .rdata_i(rdata), .done_o(done), .fail_o(fail)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // flash model state
   logic [31:0] cur_vec = '0;
   int pulses [NB];
   int last_idx, order_bad, addr_err, prog_rises, exp_addr, first_wr;
   int t_prog_r, t_sel_r, t_setup_r, t_setup_f, t_pulse_r, t_pulse_f;
   int t_wdog_f, t_ver_r, t_ver_f, t_wr1, t_wr, t_rd, t_done_r, g_retry;
   logic p_prog, p_setup, p_pulse, p_wdog, p_ver, p_done;
   logic [NB-1:0] p_sel;

   function automatic int need_of(input logic [31:0] v, input int b);
      return int'(v[b*7 +: 7]);
   endfunction

   function automatic int bad_word(input int b);
      return (b == 1) ? BW - 1 : (b == 2) ? BW / 2 : 0;
   endfunction

   always_comb begin
      int b, w;
      b = int'(addr) / (BW * 4);
      w = (int'(addr) / 4) % BW;
      rdata = 32'hFFFF_FFFF;
      if (b < NB) begin
         if (pulses[b] < need_of(cur_vec, b) && w == bad_word(b))
            rdata = 32'hFFFF_7FFF;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         int si;
         si = -1;
         for (int b = 0; b < NB; b++) if (sel[b]) si = b;
         if (prog_en && !p_prog) begin t_prog_r = cyc; prog_rises++; end
         if (sel != '0 && sel != p_sel) begin
            t_sel_r = cyc;
            if (si <= last_idx) order_bad++;
            last_idx = si;
         end
         if (setup && !p_setup) begin t_setup_r = cyc; g_retry = cyc - t_ver_f; end
         if (!setup && p_setup) t_setup_f = cyc;
         if (pulse && !p_pulse) t_pulse_r = cyc;
         if (!pulse && p_pulse) begin
            t_pulse_f = cyc;
            if (si >= 0) pulses[si]++;
         end
         if (!wdog && p_wdog) t_wdog_f = cyc;
         if (verify && !p_ver) begin t_ver_r = cyc; exp_addr = si * BW * 4; first_wr = 1; end
         if (!verify && p_ver) t_ver_f = cyc;
         if (dwr) begin
            if (first_wr != 0) t_wr1 = cyc;
            first_wr = 0;
            t_wr = cyc;
            if (dwr_data != 8'hFF || int'(addr) != exp_addr) addr_err++;
         end
         if (rd) begin
            t_rd = cyc;
            if (int'(addr) != exp_addr) addr_err++;
            if (&rdata) exp_addr += 4;
         end
         if (done && !p_done) t_done_r = cyc;
         p_prog = prog_en; p_setup = setup; p_pulse = pulse; p_wdog = wdog;
         p_ver = verify; p_done = done; p_sel = sel;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_model(input logic [31:0] v);
      cur_vec = v;
      for (int b = 0; b < NB; b++) pulses[b] = 0;
      last_idx = -1; order_bad = 0; addr_err = 0;
   endtask

   task automatic kick(input logic [NB-1:0] m);
      @(negedge clk);
      start = 1'b1; mask = m;
      @(negedge clk);
      start = 1'b0; mask = '0;
   endtask

   task automatic wait_end();
      for (int i = 0; i < 60000; i++) begin
         if (done || fail) break;
         @(negedge clk);
      end
   endtask

   task automatic run_vec(input logic [31:0] v);
      int  exp_p [NB];
      bit  exp_fail;
      bit  ok;
      exp_fail = 0;
      for (int b = 0; b < NB; b++) exp_p[b] = 0;
      for (int b = 0; b < NB; b++) begin
         if (v[28 + b] && !exp_fail) begin
            if (need_of(v, b) > MT) begin exp_p[b] = MT; exp_fail = 1; end
            else exp_p[b] = need_of(v, b);
         end
      end
      clear_model(v);
      kick(v[31:28]);
      wait_end();
      @(negedge clk);
      ok = 1;
      for (int b = 0; b < NB; b++) begin
         if (pulses[b] != exp_p[b]) begin
            ok = 0;
            check(0, "R8 pulses per block", pulses[b], exp_p[b]);
         end
      end
      if (ok) check(1, "R8", 0, 0);
      check(fail == exp_fail, "R9 fail flag", fail, exp_fail);
      check(done == !exp_fail, "R10 done flag", done, !exp_fail);
      check(!prog_en && sel == '0, "R10 enable dropped", prog_en, 0);
      check(order_bad == 0, "R3 ascending order", order_bad, 0);
      check(addr_err == 0, "R7 verify addresses", addr_err, 0);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      int pr;
      start = 1'b0; mask = '0;
      prog_rises = 0;
      p_prog = 0; p_setup = 0; p_pulse = 0; p_wdog = 0; p_ver = 0; p_done = 0; p_sel = '0;
      clear_model(32'h0);
      repeat (3) @(negedge clk);
      check(!prog_en && !setup && !pulse && !verify && !wdog && !dwr && !rd && sel == '0 && !done && !fail,
            "R1 reset state", int'(prog_en), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!prog_en && sel == '0 && !done && !fail, "R1 after reset", int'(prog_en), 0);

      // table walk
      for (int v = 0; v < NV; v++) run_vec(VEC[v]);

      // R12: fail holds, then clears on next start (vector 3 failed)
      run_vec(VEC[3]);
      repeat (50) @(negedge clk);
      check(fail && !done, "R12 fail holds", fail, 1);
      clear_model(32'h1000_0001);
      kick(4'b0001);
      check(!fail && !done, "R12 start clears flags", fail, 0);
      wait_end();
      @(negedge clk);

      // timing of one clean single-pulse block (still the run just started)
      check(t_sel_r - t_prog_r == 10 * CPU, "R2 enable to select", t_sel_r - t_prog_r, 10 * CPU);
      check(t_setup_r == t_sel_r, "R4 setup with select", t_setup_r, t_sel_r);
      check(t_pulse_r - t_setup_r == TSU * CPU, "R4 setup to pulse", t_pulse_r - t_setup_r, TSU * CPU);
      check(t_pulse_f - t_pulse_r == TPU * CPU, "R4 pulse width", t_pulse_f - t_pulse_r, TPU * CPU);
      check(t_setup_f - t_pulse_f == 10 * CPU, "R4 pulse to setup drop", t_setup_f - t_pulse_f, 10 * CPU);
      check(t_ver_r - t_setup_f == 10 * CPU, "R5 watchdog hold", t_ver_r - t_setup_f, 10 * CPU);
      check(t_wdog_f == t_ver_r, "R5 watchdog off at verify", t_wdog_f, t_ver_r);
      check(t_wr1 - t_ver_r == 20 * CPU, "R6 verify to first write", t_wr1 - t_ver_r, 20 * CPU);
      check(t_rd - t_wr == 2 * CPU + 1, "R7 write to read", t_rd - t_wr, 2 * CPU + 1);
      check(t_done_r - t_ver_f == 5 * CPU, "R10 verify off to done", t_done_r - t_ver_f, 5 * CPU);

      // R8: retry restarts setup after the verify-off wait
      run_vec(32'h1000_0002);
      check(g_retry == 5 * CPU, "R8 retry gap", g_retry, 5 * CPU);

      // R11: second start while busy is ignored
      clear_model(32'h1000_0001);
      kick(4'b0001);
      repeat (30) @(negedge clk);
      start = 1'b1; mask = 4'b1110;
      @(negedge clk);
      start = 1'b0; mask = '0;
      wait_end();
      @(negedge clk);
      check(pulses[1] + pulses[2] + pulses[3] == 0 && pulses[0] == 1, "R11 start while busy",
            pulses[1] + pulses[2] + pulses[3], 0);
      check(done && !fail, "R11 run completes", done, 1);

      // R12: done holds
      repeat (40) @(negedge clk);
      check(done && !fail, "R12 done holds", done, 1);

      // R13: empty mask
      run_vec(32'h0);
      pr = prog_rises;
      clear_model(32'h0);
      kick(4'b0000);
      check(done && !fail, "R13 empty mask done", done, 1);
      repeat (10) @(negedge clk);
      check(prog_rises == pr && !prog_en && !setup && !verify && sel == '0, "R13 no strobes",
            prog_rises - pr, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule